// File: doc/BRIEF.md
# ATA PIO Host Cycle Sequencer

This block sits on the host side of a parallel ATA link and runs one programmed-I/O register or data transfer per request. A request gives a register address, a direction, write data and a flag that marks an 8-bit register access. The block drives the address lines, the active-low read and write strobes, the write-data bus and its output enable. It returns read data, a one-cycle done pulse and an error flag.

The timing of each transfer follows the PIO mode (0 to 6) presented at the moment the request is accepted. Every nanosecond minimum is turned into a clock count by rounding up against the `CLK_NS` parameter, so no phase is ever shorter than its minimum. Each transfer has three phases: address setup, strobe active and strobe recovery. The block lengthens recovery until the whole transfer also meets the mode's minimum cycle time. In modes 0 to 4 the device can hold the strobe active by keeping IORDY low. A stall that lasts longer than the timeout forces the transfer to finish with the error flag set.

Top module: `pio_host_seq`

## Requirements
- R1: After a synchronous active-low reset, both strobes are high, the write-data enable is low, `req_ready` is high and `rsp_done` and `rsp_err` are low.
- R2: After acceptance, the address is driven with both strobes high for exactly ceil(S/CLK_NS) cycles before a strobe falls, where S is 70, 50, 30, 30, 25, 15, 10 ns for modes 0..6. The address stays stable until the transfer ends.
- R3: The strobe is low for at least ceil(A/CLK_NS) cycles, and exactly that many when IORDY does not stretch it. A is 165, 125, 100, 80, 70, 65, 55 ns for modes 0..6. For 8-bit accesses (`req_byte`=1) in modes 0, 1 and 2, A is 290 ns instead.
- R4: The recovery count is the largest of four values: the mode's recovery minimum (0, 0, 0, 70, 25, 25, 20 ns), the address hold (20, 15, 10, 10, 10, 10, 10 ns), the write hold for writes (30, 20, 15, 10, 10, 5, 5 ns) and the bus release time for reads (30 ns in modes 0..4, 20 ns in modes 5 and 6). Each value is converted to cycles. The busy length (cycles with `req_ready` low) is the larger of ceil(C/CLK_NS) and setup+active+recovery, where C is 600, 383, 240, 180, 120, 100, 80 ns. `rsp_done` is a one-cycle pulse in the first cycle after the busy cycles.
- R5: A read captures `ata_din` on the clock edge that ends the strobe-low phase. `rsp_rdata` returns the full word for 16-bit accesses, or bits 7:0 with the upper bits zero for 8-bit accesses.
- R6: During a write, `ata_dout_en` is high and `ata_dout` carries the request data for every busy cycle (upper byte zero for 8-bit accesses). During a read, `ata_dout_en` stays low.
- R7: After a read, the write-data enable stays low through the whole recovery phase, which is at least the bus release time, so a following write cannot collide with the device.
- R8: In modes 0..4, once the minimum strobe width has elapsed, the strobe stays low while IORDY is sampled low. It rises after the first rising clock edge that samples IORDY high.
- R9: In modes 5 and 6, IORDY has no effect: the strobe width equals the R3 count even with IORDY held low, and `rsp_err` stays low.
- R10: If IORDY stays low for ceil(`IORDY_TMO_NS`/CLK_NS) cycles after the minimum width, the strobe is released and `rsp_err` is high together with `rsp_done`.
- R11: `pio_mode` is sampled only when a request is accepted; changing it during a transfer does not change that transfer's timing. `req_ready` is high only when no transfer is in progress.
- R12: Mode code 7 uses the mode 0 timing.
- R13: The read and write strobes are never low at the same time, and the strobe matches the request direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_byte | input | 1 | 1 = 8-bit register access, 0 = 16-bit data access |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| pio_mode | input | 3 | PIO mode code, sampled on acceptance |
| rsp_done | output | 1 | One-cycle pulse when a transfer ends |
| rsp_err | output | 1 | IORDY timeout, valid with rsp_done |
| rsp_rdata | output | DATA_W | Captured read data |
| ata_addr | output | ADDR_W | Address lines to the device |
| ata_rd_n | output | 1 | Active-low read strobe |
| ata_wr_n | output | 1 | Active-low write strobe |
| ata_dout | output | DATA_W | Write data to the device |
| ata_dout_en | output | 1 | Output enable for ata_dout |
| ata_din | input | DATA_W | Read data from the device |
| ata_iordy | input | 1 | Device ready, low stretches the strobe |

## Verification
The bench builds the block with its defaults: `CLK_NS` = 10, `ADDR_W` = 3, `DATA_W` = 16, and `IORDY_TMO_NS` = 1250 (125 cycles). With a 10 ns count base, all seven mode rows give distinct phase counts. In some transfers the cycle-time minimum sets the length, and in others the sum of the three phases does, so both branches of the busy-length rule are exercised. With a 125-cycle timeout, a full IORDY stall finishes in about 150 cycles, and a short stretch of 20 cycles can be told apart from both the minimum width and the timeout.

// File: rtl/pio_pkg.sv
// Shared types and timing conversion for the PIO host sequencer.
// Assumes every count fits in CW bits at the chosen clock period.
package pio_pkg;
    localparam int CW = 8;
    typedef logic [CW-1:0] cnt_t;

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_REC} phase_e;

    // Per-mode phase minimums, already in clock cycles
    typedef struct packed {
        cnt_t setup;   // address valid to strobe
        cnt_t act16;   // strobe width, 16-bit data
        cnt_t act8;    // strobe width, 8-bit register
        cnt_t recov;   // strobe inactive minimum
        cnt_t ahold;   // address hold after strobe
        cnt_t whold;   // write data hold after strobe
        cnt_t rdz;     // device bus release after read strobe
        cnt_t cycle;   // whole transfer minimum
        logic rdy_en;  // IORDY honoured in this mode
    } pio_tim_t;

    // Round a nanosecond minimum up to whole clock cycles
    function automatic cnt_t ns_to_cnt(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return cnt_t'(c);
    endfunction

    // Timing row for one mode; any code outside 1..6 takes mode 0
    function automatic pio_tim_t mode_tim(input int m, input int clk_ns);
        int s, a, a8, r, h, w, z, c;
        logic e;
        case (m)
            1:       begin s = 50; a = 125; a8 = 290; r = 0;  h = 15; w = 20; z = 30; c = 383; e = 1'b1; end
            2:       begin s = 30; a = 100; a8 = 290; r = 0;  h = 10; w = 15; z = 30; c = 240; e = 1'b1; end
            3:       begin s = 30; a = 80;  a8 = 80;  r = 70; h = 10; w = 10; z = 30; c = 180; e = 1'b1; end
            4:       begin s = 25; a = 70;  a8 = 70;  r = 25; h = 10; w = 10; z = 30; c = 120; e = 1'b1; end
            5:       begin s = 15; a = 65;  a8 = 65;  r = 25; h = 10; w = 5;  z = 20; c = 100; e = 1'b0; end
            6:       begin s = 10; a = 55;  a8 = 55;  r = 20; h = 10; w = 5;  z = 20; c = 80;  e = 1'b0; end
            default: begin s = 70; a = 165; a8 = 290; r = 0;  h = 20; w = 30; z = 30; c = 600; e = 1'b1; end
        endcase
        return '{setup: ns_to_cnt(s, clk_ns), act16: ns_to_cnt(a, clk_ns),
                 act8: ns_to_cnt(a8, clk_ns), recov: ns_to_cnt(r, clk_ns),
                 ahold: ns_to_cnt(h, clk_ns), whold: ns_to_cnt(w, clk_ns),
                 rdz: ns_to_cnt(z, clk_ns), cycle: ns_to_cnt(c, clk_ns),
                 rdy_en: e};
    endfunction
endpackage

// File: rtl/pio_mode_lut.sv
// Mode-to-timing lookup. Builds one constant row per 3-bit mode code
// and selects the row for the presented code. Code 7 falls back to mode 0.
module pio_mode_lut
    import pio_pkg::*;
#(
    parameter int CLK_NS = 10
) (
    input  logic [2:0] mode,
    output pio_tim_t   tim
);
    localparam int NCODE = 8;

    pio_tim_t tbl [NCODE];

    // One constant row per mode code
    for (genvar g = 0; g < NCODE; g++) begin : g_row
        assign tbl[g] = mode_tim((g > 6) ? 0 : g, CLK_NS);
    end

    // Select the row for the presented mode
    assign tim = tbl[mode];
endmodule

// File: rtl/pio_rdy_guard.sv
// IORDY stall watch. Once the minimum strobe width is over (armed), a low
// IORDY holds the strobe; after TMO_CYC stalled cycles a timeout ends it.
// Assumes IORDY is already synchronised to clk.
module pio_rdy_guard #(
    parameter int TMO_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic rdy_en,
    input  logic iordy,
    output logic may_end,
    output logic timeout
);
    localparam int TW = $clog2(TMO_CYC + 1);

    logic [TW-1:0] scnt;
    logic          stall;

    assign stall   = armed && rdy_en && !iordy;
    assign timeout = stall && (scnt == TW'(TMO_CYC - 1));
    assign may_end = !stall || timeout;

    // Count consecutive stalled cycles, clear whenever not stalled
    always_ff @(posedge clk) begin
        if (!rst_n)                 scnt <= '0;
        else if (stall && !timeout) scnt <= scnt + 1'b1;
        else                        scnt <= '0;
    end

    p_stall_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        scnt <= TW'(TMO_CYC - 1));
endmodule

// File: rtl/pio_cycle_fsm.sv
// Phase sequencer: setup, strobe active, recovery. Recovery is held until
// both its own minimum and the whole-transfer minimum are met.
// Assumes the timing row and direction are stable for the whole transfer.
module pio_cycle_fsm
    import pio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     is_wr,
    input  logic     is_byte,
    input  pio_tim_t tim,
    input  logic     may_end,
    input  logic     timeout,
    output phase_e   ph,
    output logic     armed,
    output logic     act_end,
    output logic     done,
    output logic     err
);
    cnt_t pcnt, tcnt, act_need, rec_need;
    logic rec_end, err_q;

    // Strobe width for this access size
    always_comb act_need = is_byte ? tim.act8 : tim.act16;

    // Recovery is the largest applicable hold or release minimum
    always_comb begin
        rec_need = tim.recov;
        if (tim.ahold > rec_need)           rec_need = tim.ahold;
        if (is_wr && tim.whold > rec_need)  rec_need = tim.whold;
        if (!is_wr && tim.rdz > rec_need)   rec_need = tim.rdz;
        if (rec_need == '0)                 rec_need = cnt_t'(1);
    end

    assign armed   = (ph == PH_ACT) && (pcnt >= act_need - cnt_t'(1));
    assign act_end = armed && may_end;
    assign rec_end = (ph == PH_REC) && (pcnt >= rec_need - cnt_t'(1))
                     && (tcnt >= tim.cycle - cnt_t'(1));

    // Phase register and per-phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph   <= PH_IDLE;
            pcnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    pcnt <= '0;
                    if (start) ph <= PH_SETUP;
                end
                PH_SETUP: begin
                    if (pcnt >= tim.setup - cnt_t'(1)) begin
                        ph   <= PH_ACT;
                        pcnt <= '0;
                    end else begin
                        pcnt <= pcnt + cnt_t'(1);
                    end
                end
                PH_ACT: begin
                    if (act_end) begin
                        ph   <= PH_REC;
                        pcnt <= '0;
                    end else if (pcnt != '1) begin
                        pcnt <= pcnt + cnt_t'(1);
                    end
                end
                default: begin
                    if (rec_end) begin
                        ph   <= PH_IDLE;
                        pcnt <= '0;
                    end else if (pcnt != '1) begin
                        pcnt <= pcnt + cnt_t'(1);
                    end
                end
            endcase
        end
    end

    // Whole-transfer counter, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || ph == PH_IDLE) tcnt <= '0;
        else if (tcnt != '1)         tcnt <= tcnt + cnt_t'(1);
    end

    // Done pulse and timeout flag for the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            err   <= 1'b0;
            err_q <= 1'b0;
        end else begin
            done <= rec_end;
            err  <= rec_end && err_q;
            if (start)        err_q <= 1'b0;
            else if (act_end) err_q <= timeout;
        end
    end

    p_min_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_REC && $past(ph) == PH_ACT) |-> ($past(pcnt) >= $past(act_need) - cnt_t'(1)));
    p_min_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_IDLE && $past(ph) == PH_REC) |-> ($past(tcnt) >= $past(tim.cycle) - cnt_t'(1)));
endmodule

// File: rtl/pio_host_seq.sv
// Host-side PIO transfer sequencer top. Latches one request and its mode
// timing, runs the phase sequencer, drives the bus and returns the response.
// Assumes ata_din and ata_iordy are synchronous to clk.
module pio_host_seq
    import pio_pkg::*;
#(
    parameter int CLK_NS       = 10,
    parameter int ADDR_W       = 3,
    parameter int DATA_W       = 16,
    parameter int IORDY_TMO_NS = 1250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_byte,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [2:0]        pio_mode,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ata_addr,
    output logic              ata_rd_n,
    output logic              ata_wr_n,
    output logic [DATA_W-1:0] ata_dout,
    output logic              ata_dout_en,
    input  logic [DATA_W-1:0] ata_din,
    input  logic              ata_iordy
);
    localparam int TMO_CYC = (IORDY_TMO_NS + CLK_NS - 1) / CLK_NS;
    localparam int HI_W    = DATA_W - 8;

    pio_tim_t          tim_live, tim_q;
    phase_e            ph;
    logic              start, armed, act_end, may_end, timeout;
    logic              wr_q, byte_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;

    assign req_ready = (ph == PH_IDLE);
    assign start     = req_valid && req_ready;

    pio_mode_lut #(.CLK_NS(CLK_NS)) u_lut (
        .mode (pio_mode),
        .tim  (tim_live)
    );

    // Latch the request and its mode timing on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q   <= '0;
            wr_q    <= 1'b0;
            byte_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            tim_q   <= tim_live;
            wr_q    <= req_write;
            byte_q  <= req_byte;
            addr_q  <= req_addr;
            wdata_q <= req_byte ? {{HI_W{1'b0}}, req_wdata[7:0]} : req_wdata;
        end
    end

    pio_cycle_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .is_wr   (wr_q),
        .is_byte (byte_q),
        .tim     (tim_q),
        .may_end (may_end),
        .timeout (timeout),
        .ph      (ph),
        .armed   (armed),
        .act_end (act_end),
        .done    (rsp_done),
        .err     (rsp_err)
    );

    pio_rdy_guard #(.TMO_CYC(TMO_CYC)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (armed),
        .rdy_en  (tim_q.rdy_en),
        .iordy   (ata_iordy),
        .may_end (may_end),
        .timeout (timeout)
    );

    // Capture read data on the edge that ends the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)                rdata_q <= '0;
        else if (act_end && !wr_q) rdata_q <= byte_q ? {{HI_W{1'b0}}, ata_din[7:0]} : ata_din;
    end

    assign rsp_rdata   = rdata_q;
    assign ata_addr    = addr_q;
    assign ata_rd_n    = !((ph == PH_ACT) && !wr_q);
    assign ata_wr_n    = !((ph == PH_ACT) && wr_q);
    assign ata_dout    = wdata_q;
    assign ata_dout_en = wr_q && (ph != PH_IDLE);

    p_one_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_rd_n && !ata_wr_n));
    p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ata_rd_n && ata_wr_n));
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(ata_addr));
    p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_rd_n |-> !ata_dout_en);
endmodule

// File: tb/pio_host_seq_bench.sv
// Scoreboard bench: the driver pushes expected transfer shapes, the monitor
// measures each transfer at the ports and compares on the done pulse.
module pio_host_seq_bench;
    localparam int CLK_NS_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
    logic [2:0]  req_addr = '0, pio_mode = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, rsp_err, ata_rd_n, ata_wr_n, ata_dout_en, ata_iordy;
    logic [15:0] rsp_rdata, ata_dout, ata_din;
    logic [2:0]  ata_addr;

    int  n_cmp = 0, n_bad = 0;
    bit  finished = 0;
    bit  force_low = 0;
    int  stretch_k = 0;
    int  dev_low = 0;

    always #10 clk = !clk;

    pio_host_seq u_pio_host_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr),
        .req_wdata(req_wdata), .pio_mode(pio_mode), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ata_addr(ata_addr),
        .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .ata_dout(ata_dout),
        .ata_dout_en(ata_dout_en), .ata_din(ata_din), .ata_iordy(ata_iordy)
    );

    // Device model: data valid only while read strobe is low
    assign ata_din   = ata_rd_n ? 16'hDEAD : {8'hA5, 5'b0, ata_addr};
    assign ata_iordy = !force_low && (dev_low >= stretch_k);

    typedef struct {
        int setup; int low_lo; int low_hi; int rec; int cyc;
        bit wr; logic [15:0] wdata; logic [15:0] rdata; bit chk_rd; bit err;
        string tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int cdiv(input int ns);
        return (ns + CLK_NS_P - 1) / CLK_NS_P;
    endfunction

    // Expected counts from the requirement tables
    function automatic exp_t shape(input int mode, input bit wr, input bit byt);
        int s[7]  = '{70, 50, 30, 30, 25, 15, 10};
        int a[7]  = '{165, 125, 100, 80, 70, 65, 55};
        int r[7]  = '{0, 0, 0, 70, 25, 25, 20};
        int h[7]  = '{20, 15, 10, 10, 10, 10, 10};
        int w[7]  = '{30, 20, 15, 10, 10, 5, 5};
        int z[7]  = '{30, 30, 30, 30, 30, 20, 20};
        int c[7]  = '{600, 383, 240, 180, 120, 100, 80};
        exp_t e;
        int m, rc;
        m = (mode > 6) ? 0 : mode;
        e.setup = cdiv(s[m]);
        e.low_lo = (byt && m <= 2) ? cdiv(290) : cdiv(a[m]);
        e.low_hi = e.low_lo;
        rc = cdiv(r[m]);
        if (cdiv(h[m]) > rc) rc = cdiv(h[m]);
        if (wr && cdiv(w[m]) > rc) rc = cdiv(w[m]);
        if (!wr && cdiv(z[m]) > rc) rc = cdiv(z[m]);
        e.rec = rc;
        e.cyc = cdiv(c[m]);
        e.wr = wr; e.err = 0; e.chk_rd = !wr; e.wdata = '0; e.rdata = '0;
        return e;
    endfunction

    // Driver: push expectation, present request for one accepted cycle
    task automatic issue(input int mode, input bit wr, input bit byt, input logic [2:0] addr,
                         input logic [15:0] wd, input int post_mode, input exp_t e, input string tag);
        e.tag = tag;
        e.wdata = byt ? {8'h00, wd[7:0]} : wd;
        e.rdata = byt ? {8'h00, 5'b0, addr} : {8'hA5, 5'b0, addr};
        sb.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_byte = byt; req_addr = addr;
        req_wdata = wd; pio_mode = 3'(mode);
        @(negedge clk);
        req_valid = 0; pio_mode = 3'(post_mode);
        while (!req_ready) @(negedge clk);
    endtask

    // Monitor: measure phases at the pins, compare at done
    int busy = 0, low = 0, setup = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ata_rd_n || !ata_wr_n) dev_low = dev_low + 1; else dev_low = 0;
            if (!ata_rd_n && !ata_wr_n) check(0, "R13 both strobes low", 1, 0);
            if (!req_ready) begin
                busy++;
                if (ata_rd_n && ata_wr_n && low == 0) setup++;
                if (sb.size() > 0) begin
                    if (sb[0].wr && !(ata_dout_en && ata_dout == sb[0].wdata))
                        check(0, "R6 write bus", int'(ata_dout), int'(sb[0].wdata));
                    if (!sb[0].wr && ata_dout_en) check(0, "R6/R7 enable on read", 1, 0);
                    if (sb[0].wr ? !ata_rd_n : !ata_wr_n) check(0, "R13 strobe direction", 1, 0);
                end
            end
            if (!ata_rd_n || !ata_wr_n) low++;
            if (rsp_done) begin
                if (sb.size() == 0) check(0, "R4 unexpected done", 1, 0);
                else begin
                    exp_t e;
                    int eb;
                    e = sb.pop_front();
                    eb = e.setup + low + e.rec;
                    if (e.cyc > eb) eb = e.cyc;
                    check(setup == e.setup, {"R2 setup ", e.tag}, setup, e.setup);
                    check(low >= e.low_lo && low <= e.low_hi, {"R3 strobe width ", e.tag}, low, e.low_lo);
                    check(busy == eb, {"R4 busy length ", e.tag}, busy, eb);
                    check(rsp_err == e.err, {"R10 error flag ", e.tag}, int'(rsp_err), int'(e.err));
                    if (e.chk_rd) check(rsp_rdata == e.rdata, {"R5 read data ", e.tag}, int'(rsp_rdata), int'(e.rdata));
                end
                busy = 0; low = 0; setup = 0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still summarises
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        exp_t e;
        repeat (3) @(negedge clk);
        check(ata_rd_n && ata_wr_n && !ata_dout_en && req_ready && !rsp_done && !rsp_err,
              "R1 reset state", 0, 1);
        rst_n = 1;
        @(negedge clk);
        check(ata_rd_n && ata_wr_n && !ata_dout_en && req_ready && !rsp_done, "R1 after release", 0, 1);

        // R3 R4 R5: slow mode reads, 16 and 8 bit
        issue(0, 0, 0, 3'd3, 16'h0, 0, shape(0, 0, 0), "m0 rd16");
        issue(0, 0, 1, 3'd5, 16'h0, 0, shape(0, 0, 1), "m0 rd8");
        issue(1, 0, 0, 3'd1, 16'h0, 1, shape(1, 0, 0), "m1 rd16");
        // R6: writes, 8-bit long strobe and fast modes
        issue(2, 1, 1, 3'd6, 16'hBE7C, 2, shape(2, 1, 1), "m2 wr8");
        issue(3, 0, 0, 3'd2, 16'h0, 3, shape(3, 0, 0), "m3 rd16");
        issue(4, 1, 0, 3'd4, 16'h1234, 4, shape(4, 1, 0), "m4 wr16");
        issue(5, 1, 0, 3'd7, 16'hC0DE, 5, shape(5, 1, 0), "m5 wr16");
        // R7: read then write back to back in the fastest mode
        issue(6, 0, 1, 3'd0, 16'h0, 6, shape(6, 0, 1), "m6 rd8");
        issue(6, 1, 0, 3'd2, 16'h5AA5, 6, shape(6, 1, 0), "m6 wr after rd");
        // R11: mode changes right after acceptance
        issue(3, 1, 0, 3'd1, 16'h0F0F, 0, shape(3, 1, 0), "m3 wr mode change");
        // R12: code 7 takes mode 0 timing
        issue(7, 0, 0, 3'd4, 16'h0, 0, shape(0, 0, 0), "m7 rd16");

        // R8: IORDY stretch in mode 4 for about 20 strobe cycles
        stretch_k = 20;
        e = shape(4, 0, 0); e.low_lo = 20; e.low_hi = 22;
        issue(4, 0, 0, 3'd3, 16'h0, 4, e, "m4 iordy stretch");
        stretch_k = 0;

        // R9: IORDY held low is ignored in mode 5
        force_low = 1;
        issue(5, 0, 0, 3'd2, 16'h0, 5, shape(5, 0, 0), "m5 iordy ignored");

        // R10: IORDY held low in mode 0 times out
        e = shape(0, 0, 0); e.low_lo = 135; e.low_hi = 145; e.err = 1; e.chk_rd = 0;
        issue(0, 0, 0, 3'd1, 16'h0, 0, e, "m0 iordy timeout");
        force_low = 0;

        // R10: next transfer reports no stale error
        issue(6, 0, 0, 3'd5, 16'h0, 6, shape(6, 0, 0), "m6 after timeout");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R4 all transfers completed", sb.size(), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule